// File: doc/BRIEF.md
# GPIO Data Port with Atomic Bit Updates

This block is a 32-pin general-purpose I/O data port on a small word-addressed register bus. It has an output data word and a direction word, and it brings the pin levels in through a synchroniser. Three write-only registers let software raise, lower or invert any chosen set of output bits with a single write. No read-modify-write sequence is needed, so two agents that update different pins cannot overwrite each other.

The bus has a byte address, a write strobe, write data and read data. Read data is combinational from the address. A write is captured on the rising clock edge and takes effect from the next cycle. Each pad gets an output level and an output enable, and each pad level comes back in on `pad_in`. Pin muxing, pulls, drive strength and interrupt detection belong to other blocks.

Top module: `pio_bank`

## Requirements
- R1: While `rst_n` is low, and after reset, `pad_out` and `pad_oe` are all zero, so every pin starts as an input. The output word at 0x00 and the direction word at 0x14 read back as zero.
- R2: A write to byte address 0x00 loads the whole output word from `bus_wdata`. The new value appears on `pad_out` in the cycle after the write edge.
- R3: A write to 0x04 sets every output bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R4: A write to 0x08 clears every output bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R5: A write to 0x0C inverts every output bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R6: Addresses 0x04, 0x08 and 0x0C always read as zero.
- R7: Address 0x14 is a read-write direction word. Bit n at 1 makes pin n an output, so `pad_oe[n]` is 1. Bit n at 0 makes pin n an input.
- R8: `pad_out` always carries the output word, whatever the direction. A read at 0x00 returns that same driven value.
- R9: A read at 0x10 returns `pad_in` as it was sampled two rising edges earlier. The pin levels pass through a two-flop synchroniser.
- R10: A write to 0x10 changes neither the output word nor the direction word.
- R11: Every other address, including misaligned ones such as 0x02, reads as zero. A write to such an address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Output level for each pad |
| pad_oe | output | 32 | Output enable for each pad, 1 = drive |

## Verification
Two things can happen in the same cycle: a pin level changes at the synchroniser input, and the bus writes to the input address 0x10. The write must be dropped, and the new level must still arrive at the input register two edges later. The bench provokes this on purpose by changing `pad_in` on the very clock edge of a write to 0x10. It then reads back the input word, the output word and the direction word, and compares them with its own model.

In the randomized phase, pin changes are mixed with set, clear and toggle writes in the same cycles. This shows that the path that changes output bits and the path that samples the pins never disturb each other.

// File: rtl/pio_bank_pkg.sv
package pio_bank_pkg;

  // Register selected by one bus access.
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_DOUT = 3'd1,
    SEL_SET  = 3'd2,
    SEL_CLR  = 3'd3,
    SEL_TGL  = 3'd4,
    SEL_DIN  = 3'd5,
    SEL_DIR  = 3'd6
  } pio_sel_e;

  // Byte offsets of the port registers.
  localparam logic [7:0] OFF_DOUT = 8'h00;
  localparam logic [7:0] OFF_SET  = 8'h04;
  localparam logic [7:0] OFF_CLR  = 8'h08;
  localparam logic [7:0] OFF_TGL  = 8'h0C;
  localparam logic [7:0] OFF_DIN  = 8'h10;
  localparam logic [7:0] OFF_DIR  = 8'h14;

endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] chain_q;

  // Reset is asserted at once, and released only after STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = chain_q[STAGES-1];

endmodule

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage_q [STAGES];

  // Each stage samples the stage before it on every clock edge.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_in;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_bank_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      din,
  output logic [W-1:0]      dout_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      rdata
);

  localparam int OFF_W = 8;

  pio_sel_e     sel;
  logic [W-1:0] dout_d;
  logic         dout_en;
  logic         dir_en;

  // Decode the address. Only an exact match selects a register, so
  // misaligned and out-of-map addresses select nothing.
  always_comb begin
    logic [OFF_W-1:0] a;
    a = OFF_W'(addr);
    if (ADDR_W > OFF_W && (addr >> OFF_W) != '0) sel = SEL_NONE;
    else begin
      unique case (a)
        OFF_DOUT: sel = SEL_DOUT;
        OFF_SET:  sel = SEL_SET;
        OFF_CLR:  sel = SEL_CLR;
        OFF_TGL:  sel = SEL_TGL;
        OFF_DIN:  sel = SEL_DIN;
        OFF_DIR:  sel = SEL_DIR;
        default:  sel = SEL_NONE;
      endcase
    end
  end

  // Next-state logic for the output word and the direction word.
  always_comb begin
    dout_d  = dout_q;
    dout_en = 1'b0;
    dir_en  = 1'b0;
    if (wr) begin
      unique case (sel)
        SEL_DOUT: begin dout_d = wdata;           dout_en = 1'b1; end
        SEL_SET:  begin dout_d = dout_q | wdata;  dout_en = 1'b1; end
        SEL_CLR:  begin dout_d = dout_q & ~wdata; dout_en = 1'b1; end
        SEL_TGL:  begin dout_d = dout_q ^ wdata;  dout_en = 1'b1; end
        SEL_DIR:  dir_en = 1'b1;
        default:  ;
      endcase
    end
  end

  // Registers, each loaded only when its enable is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
    end else begin
      if (dout_en) dout_q <= dout_d;
      if (dir_en)  dir_q  <= wdata;
    end
  end

  // Read multiplexer. The write-only registers read as zero.
  always_comb begin
    unique case (sel)
      SEL_DOUT: rdata = dout_q;
      SEL_DIN:  rdata = din;
      SEL_DIR:  rdata = dir_q;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/pio_bank.sv
module pio_bank #(
  parameter int W           = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe
);

  logic         rst_core_n;
  logic [W-1:0] din_sync;
  logic [W-1:0] dout_q;
  logic [W-1:0] dir_q;

  pio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  pio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in (pad_in),
    .sync_out (din_sync)
  );

  pio_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .addr   (bus_addr),
    .wr     (bus_wr),
    .wdata  (bus_wdata),
    .din    (din_sync),
    .dout_q (dout_q),
    .dir_q  (dir_q),
    .rdata  (bus_rdata)
  );

  assign pad_out = dout_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk #(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic [W-1:0]      pad_in,
  input logic [W-1:0]      pad_out,
  input logic [W-1:0]      pad_oe
);

  // Counts cycles since reset was released. The reset synchroniser and the
  // pin synchroniser need a few cycles before the properties apply.
  logic [2:0] age_q;
  logic       settled;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age_q <= '0;
    else if (age_q != 7) age_q <= age_q + 3'd1;
  end
  assign settled = (age_q >= 3'd5);

  logic a_dout, a_set, a_clr, a_tgl, a_din, a_dir;
  assign a_dout = (bus_addr == ADDR_W'('h00));
  assign a_set  = (bus_addr == ADDR_W'('h04));
  assign a_clr  = (bus_addr == ADDR_W'('h08));
  assign a_tgl  = (bus_addr == ADDR_W'('h0C));
  assign a_din  = (bus_addr == ADDR_W'('h10));
  assign a_dir  = (bus_addr == ADDR_W'('h14));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (pad_out == '0 && pad_oe == '0));

  // R2
  load_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settled && bus_wr && a_dout |=> pad_out == $past(bus_wdata));

  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settled && bus_wr && a_set |=> pad_out == ($past(pad_out) | $past(bus_wdata)));

  // R4
  clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settled && bus_wr && a_clr |=> pad_out == ($past(pad_out) & ~$past(bus_wdata)));

  // R5
  toggle_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settled && bus_wr && a_tgl |=> pad_out == ($past(pad_out) ^ $past(bus_wdata)));

  // R6
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_set || a_clr || a_tgl) |-> bus_rdata == '0);

  // R7
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settled && bus_wr && a_dir |=> pad_oe == $past(bus_wdata));

  // R8
  dout_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_dout |-> bus_rdata == pad_out);

  // R9
  din_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settled && a_din |-> bus_rdata == $past(pad_in, 2));

  // R10 R11
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settled && !(bus_wr && (a_dout || a_set || a_clr || a_tgl)) |=> $stable(pad_out));

  // R10 R11
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settled && !(bus_wr && a_dir) |=> $stable(pad_oe));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_dout || a_set || a_clr || a_tgl || a_din || a_dir) |-> bus_rdata == '0);

endmodule

bind pio_bank pio_bank_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_pio_bank.sv
`timescale 1ns/1ps
module sim_pio_bank;

  localparam int W = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_wr;
  logic [W-1:0]  bus_wdata;
  logic [W-1:0]  bus_rdata;
  logic [W-1:0]  pad_in;
  logic [W-1:0]  pad_out;
  logic [W-1:0]  pad_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [W-1:0] exp_dout = '0;
  logic [W-1:0] exp_dir  = '0;
  logic [W-1:0] pin_h1 = '0, pin_h2 = '0;

  always #2.5 clk = ~clk;

  pio_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // Pin history: the level seen at the last edge and at the edge before it.
  always @(posedge clk) begin
    pin_h2 <= pin_h1;
    pin_h1 <= pad_in;
  end

  function automatic logic [W-1:0] next_dout(input logic [AW-1:0] a,
      input logic [W-1:0] d, input logic [W-1:0] cur);
    case (a)
      8'h00:   return d;
      8'h04:   return cur | d;
      8'h08:   return cur & ~d;
      8'h0C:   return cur ^ d;
      default: return cur;
    endcase
  endfunction

  function automatic logic [W-1:0] next_dir(input logic [AW-1:0] a,
      input logic [W-1:0] d, input logic [W-1:0] cur);
    return (a == 8'h14) ? d : cur;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act,
      input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    exp_dout = next_dout(a, d, exp_dout);
    exp_dir  = next_dir(a, d, exp_dir);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic check_state(input string tag);
    logic [W-1:0] r;
    #1;
    check({tag, " pad_out"}, pad_out, exp_dout);
    check({tag, " pad_oe"}, pad_oe, exp_dir);
    bus_read(8'h00, r); check({tag, " R8 dout read"}, r, exp_dout);
    bus_read(8'h14, r); check({tag, " R7 dir read"}, r, exp_dir);
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!finished) $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; pad_in = '0;
    #1;
    // R1 during reset
    check("R1 pad_out in reset", pad_out, '0);
    check("R1 pad_oe in reset", pad_oe, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check_state("R1 after reset");

    // R2
    bus_write(8'h00, 32'hA5A5_0F0F); check_state("R2 load");
    // R3
    bus_write(8'h04, 32'h0000_F0F0); check_state("R3 set");
    bus_write(8'h04, 32'h0000_0000); check_state("R3 set empty mask");
    // R4
    bus_write(8'h08, 32'hFFFF_0000); check_state("R4 clear");
    // R5
    bus_write(8'h0C, 32'hFFFF_FFFF); check_state("R5 toggle all");
    bus_write(8'h0C, 32'h8000_0001); check_state("R5 toggle edge bits");
    // R6
    bus_read(8'h04, r); check("R6 set reads zero", r, '0);
    bus_read(8'h08, r); check("R6 clear reads zero", r, '0);
    bus_read(8'h0C, r); check("R6 toggle reads zero", r, '0);
    // R7
    bus_write(8'h14, 32'hFFFF_FFFF); check_state("R7 all outputs");
    bus_write(8'h14, 32'h0000_FFFF); check_state("R7 half outputs");
    // R8: output word driven even on input pins
    bus_write(8'h14, 32'h0); bus_write(8'h00, 32'hDEAD_BEEF); check_state("R8 pins as inputs");

    // R9: pin latency of two edges
    @(negedge clk); pad_in = 32'h1234_5678;
    bus_addr = 8'h10; @(posedge clk); #1 check("R9 one edge old", bus_rdata, 32'h0);
    @(posedge clk); #1 check("R9 two edges", bus_rdata, 32'h1234_5678);

    // R10 collision: pin change on the edge of a write to the input address
    @(negedge clk);
    pad_in = 32'hCAFE_F00D; bus_addr = 8'h10; bus_wr = 1'b1; bus_wdata = 32'h5555_AAAA;
    @(negedge clk); bus_wr = 1'b0;
    @(negedge clk); #1 check("R10 R9 din after write", bus_rdata, 32'hCAFE_F00D);
    check_state("R10 write ignored");

    // R11
    bus_write(8'h18, 32'hFFFF_FFFF); check_state("R11 write 0x18 ignored");
    bus_write(8'h02, 32'hFFFF_FFFF); check_state("R11 write 0x02 ignored");
    bus_read(8'h18, r); check("R11 read 0x18", r, '0);
    bus_read(8'h02, r); check("R11 read 0x02", r, '0);
    bus_read(8'hFC, r); check("R11 read 0xFC", r, '0);

    // Randomized phase: pins change in the same cycles as the writes.
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic [W-1:0]  d;
      int            k;
      k = int'($urandom_range(0, 7));
      case (k)
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
        4: a = 8'h14; 5: a = 8'h10; 6: a = 8'h20; default: a = 8'h0D;
      endcase
      d = $urandom();
      @(negedge clk);
      pad_in = $urandom();
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      exp_dout = next_dout(a, d, exp_dout);
      exp_dir  = next_dir(a, d, exp_dir);
      #1;
      check("R2 R3 R4 R5 R10 R11 random pad_out", pad_out, exp_dout);
      check("R7 R10 R11 random pad_oe", pad_oe, exp_dir);
      bus_addr = 8'h10;
      @(negedge clk); #1;
      check("R9 random din", bus_rdata, pin_h2);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule